// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers event pulses and status levels from a set of peripherals into flag bits that software can see. It pairs those flags with enable bits and drives three grouped interrupt request lines toward the processor. Hardware sets a flag. Software clears it by writing a zero to its bit. Writing a one to a flag bit has no effect.

Some enables are shared. One enable bit gates both write-collision flags. Another gates both edges of the PLL-lock signal. Two wake-status flags sit in the same flag register but never raise an interrupt. The watchdog near-overflow warning flag also clears itself when the wake level falls. The PLL-lock signal is asynchronous, so it passes through a synchronizer before its edges are detected.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous active-high reset, `flags_o`, `enables_o` and all three request lines are 0.
- R2: A one-cycle event pulse sets its flag at the next rising clock edge. The flag map is: bit0 transfer-busy, bit1 one-second tick, bit2 watchdog warning, bit3 SPI, bit4 collision 0, bit5 collision 1, bit6 PLL-lock rise, bit7 PLL-lock fall, bit8 wake by timer, bit9 wake by button.
- R3: A write with `wr_sel`=1 clears every flag whose `wr_data` bit is 0. A flag whose `wr_data` bit is 1 keeps its value.
- R4: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R5: A write with `wr_sel`=0 loads `wr_data[5:0]` into the enables. The enable map is: bit0 transfer-busy, bit1 tick, bit2 watchdog warning, bit3 SPI, bit4 both collision flags, bit5 both PLL-lock edge flags.
- R6: `irq_grp6` is the registered OR of (flag0 & en0), (flag1 & en1) and (flag2 & en2). It follows the flags one cycle later.
- R7: `irq_grp2` is the registered OR of (flag3 & en3) and ((flag4 | flag5) & en4).
- R8: `irq_grp4` is the registered OR of ((flag6 | flag7) & en5).
- R9: `pll_lock` passes through a two-flop synchronizer. A rising change sets flag6, and a falling change sets flag7, at the third rising edge after the change. The flag is not set at the second edge.
- R10: A falling edge of `wake` clears flag2 at the next clock edge, unless a watchdog warning pulse arrives in the same cycle. A rising edge of `wake` leaves flag2 unchanged.
- R11: Flags 8 and 9 never drive any request line. A button pulse sets flag9 whether `wake` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_xfer_done | input | 1 | Transfer-busy event pulse |
| ev_rtc_sec | input | 1 | One-second tick pulse |
| ev_wdog_near | input | 1 | Watchdog near-overflow pulse |
| ev_spi | input | 1 | SPI event pulse |
| ev_wcol0 | input | 1 | Write-collision pulse, channel 0 |
| ev_wcol1 | input | 1 | Write-collision pulse, channel 1 |
| pll_lock | input | 1 | Asynchronous PLL-lock level |
| wake | input | 1 | Synchronous wake level |
| ev_wake_timer | input | 1 | Woke-by-timeout pulse |
| ev_button | input | 1 | Push-button pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the enable register, 1 selects the flag register |
| wr_data | input | 10 | Write data |
| flags_o | output | 10 | Flag register |
| enables_o | output | 6 | Enable register |
| irq_grp2 | output | 1 | Interrupt request line 2 |
| irq_grp4 | output | 1 | Interrupt request line 4 |
| irq_grp6 | output | 1 | Interrupt request line 6 |

## Verification
The bench sweeps every combination of the eight directly pulsed flags against several enable patterns. It also sweeps every single flag against all 64 enable patterns. A wrong bit in a line mask, or a shared enable wired to only one of its flags, would show up as a line that is wrongly high or wrongly low.

Three corner cases get targeted checks:
- A set and a clear that collide in one cycle. A design that gives priority to the clear would lose the event.
- The PLL-lock edge timing. A synchronizer that is too short or too long would move the flag one cycle away from the expected edge.
- The wake falling edge against the warning flag. If the clear fired on the wrong polarity, or overrode a new warning, flag2 would read wrong.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int NFLAG = 10;
  localparam int NEN   = 6;
  localparam int NLINE = 3;

  localparam int F_XFER  = 0;
  localparam int F_TICK  = 1;
  localparam int F_WDOG  = 2;
  localparam int F_SPI   = 3;
  localparam int F_COL0  = 4;
  localparam int F_COL1  = 5;
  localparam int F_PLLR  = 6;
  localparam int F_PLLF  = 7;
  localparam int F_WTMR  = 8;
  localparam int F_WBTN  = 9;

  typedef logic [NFLAG-1:0] flag_vec_t;
  typedef logic [NEN-1:0]   en_vec_t;

  // request line order: index 0 -> line 2, 1 -> line 4, 2 -> line 6
  localparam flag_vec_t LINE_MASK [NLINE] = '{
    10'b00_0011_1000,
    10'b00_1100_0000,
    10'b00_0000_0111
  };

  // spread the enable bits over the flags they gate
  function automatic flag_vec_t expand_en(input en_vec_t en);
    flag_vec_t r;
    r         = '0;
    r[F_XFER] = en[0];
    r[F_TICK] = en[1];
    r[F_WDOG] = en[2];
    r[F_SPI]  = en[3];
    r[F_COL0] = en[4];
    r[F_COL1] = en[4];
    r[F_PLLR] = en[5];
    r[F_PLLF] = en[5];
    return r;
  endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  // a hardware set outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_line_or.sv
module irq_line_or
  import irq_flag_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  flag_vec_t       flags,
  input  flag_vec_t       gate,
  output logic [NLINE-1:0] lines
);
  flag_vec_t live;
  assign live = flags & gate;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) lines[l] <= 1'b0;
      else     lines[l] <= |(live & LINE_MASK[l]);
    end
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_xfer_done,
  input  logic             ev_rtc_sec,
  input  logic             ev_wdog_near,
  input  logic             ev_spi,
  input  logic             ev_wcol0,
  input  logic             ev_wcol1,
  input  logic             pll_lock,
  input  logic             wake,
  input  logic             ev_wake_timer,
  input  logic             ev_button,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [NFLAG-1:0] wr_data,
  output logic [NFLAG-1:0] flags_o,
  output logic [NEN-1:0]   enables_o,
  output logic             irq_grp2,
  output logic             irq_grp4,
  output logic             irq_grp6
);
  logic       pll_rise, pll_fall;
  logic       wake_q;
  logic       wake_fall;
  flag_vec_t  set_v, clr_v, flag_q;
  en_vec_t    en_q;
  logic [NLINE-1:0] line_q;

  irq_sync_edge #(.STAGES(SYNC_STAGES)) u_pll_edge (
    .clk(clk), .rst(rst), .din(pll_lock),
    .rise(pll_rise), .fall(pll_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= wake;
  end
  assign wake_fall = wake_q & ~wake;

  always_ff @(posedge clk) begin
    if (rst)                  en_q <= '0;
    else if (wr_en && !wr_sel) en_q <= wr_data[NEN-1:0];
  end

  always_comb begin
    set_v         = '0;
    set_v[F_XFER] = ev_xfer_done;
    set_v[F_TICK] = ev_rtc_sec;
    set_v[F_WDOG] = ev_wdog_near;
    set_v[F_SPI]  = ev_spi;
    set_v[F_COL0] = ev_wcol0;
    set_v[F_COL1] = ev_wcol1;
    set_v[F_PLLR] = pll_rise;
    set_v[F_PLLF] = pll_fall;
    set_v[F_WTMR] = ev_wake_timer;
    set_v[F_WBTN] = ev_button;
  end

  always_comb begin
    clr_v = (wr_en && wr_sel) ? ~wr_data : '0;
    if (wake_fall) clr_v[F_WDOG] = 1'b1;
  end

  irq_flag_bank #(.W(NFLAG)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .q(flag_q)
  );

  irq_line_or u_lines (
    .clk(clk), .rst(rst), .flags(flag_q), .gate(expand_en(en_q)),
    .lines(line_q)
  );

  assign flags_o   = flag_q;
  assign enables_o = en_q;
  assign irq_grp2  = line_q[0];
  assign irq_grp4  = line_q[1];
  assign irq_grp6  = line_q[2];
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_xfer_done,
  input logic       ev_wdog_near,
  input logic       ev_button,
  input logic       wake,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [9:0] wr_data,
  input logic [9:0] flags_o,
  input logic [5:0] enables_o,
  input logic       irq_grp2,
  input logic       irq_grp4,
  input logic       irq_grp6
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R2
  set_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ev_xfer_done |=> flags_o[0]);

  // R4
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_xfer_done && wr_en && wr_sel && !wr_data[0]) |=> flags_o[0]);

  // R3
  write_zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && !wr_data[9] && !ev_button) |=> !flags_o[9]);

  // R3
  write_one_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && wr_data[9] && flags_o[9]) |=> flags_o[9]);

  // R6
  line6_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_o[0] && enables_o[0]) |=> irq_grp6);

  // R11
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (enables_o == 6'd0 && $stable(enables_o)) |=> !(irq_grp2 || irq_grp4 || irq_grp6));

  // R10
  wake_fall_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $fell(wake) && !ev_wdog_near) |=> !flags_o[2]);
endmodule

bind irq_flag_unit irq_flag_chk u_chk (
  .clk(clk), .rst(rst), .ev_xfer_done(ev_xfer_done), .ev_wdog_near(ev_wdog_near),
  .ev_button(ev_button), .wake(wake), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .flags_o(flags_o), .enables_o(enables_o),
  .irq_grp2(irq_grp2), .irq_grp4(irq_grp4), .irq_grp6(irq_grp6)
);

// File: tb/irq_flag_unit_test.sv
`timescale 1ns/1ps
module irq_flag_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_xfer_done = 0, ev_rtc_sec = 0, ev_wdog_near = 0, ev_spi = 0;
  logic ev_wcol0 = 0, ev_wcol1 = 0, pll_lock = 0, wake = 0;
  logic ev_wake_timer = 0, ev_button = 0, wr_en = 0, wr_sel = 0;
  logic [9:0] wr_data = '0;
  logic [9:0] flags_o;
  logic [5:0] enables_o;
  logic irq_grp2, irq_grp4, irq_grp6;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_flag_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // expected request lines {grp6, grp4, grp2} from R6, R7, R8
  function automatic logic [2:0] exp_lines(input logic [9:0] f, input logic [5:0] e);
    logic g2, g4, g6;
    g6 = (f[0] & e[0]) | (f[1] & e[1]) | (f[2] & e[2]);
    g2 = (f[3] & e[3]) | ((f[4] | f[5]) & e[4]);
    g4 = (f[6] | f[7]) & e[5];
    return {g6, g4, g2};
  endfunction

  task automatic drive_ev(input logic [9:0] m);
    ev_xfer_done = m[0]; ev_rtc_sec = m[1]; ev_wdog_near = m[2]; ev_spi = m[3];
    ev_wcol0 = m[4]; ev_wcol1 = m[5]; ev_wake_timer = m[8]; ev_button = m[9];
  endtask

  task automatic write_reg(input logic sel, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_sel = 0; wr_data = '0;
  endtask

  task automatic pulse(input logic [9:0] m);
    @(negedge clk);
    drive_ev(m);
    @(negedge clk);
    drive_ev('0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      finish_test();
    end
  end

  initial begin
    logic [9:0] f;
    logic [5:0] ens [4];
    ens[0] = 6'h3F; ens[1] = 6'h15; ens[2] = 6'h2A; ens[3] = 6'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 flags", flags_o, 0);
    chk("R1 enables", enables_o, 0);
    chk("R1 lines", {irq_grp6, irq_grp4, irq_grp2}, 0);

    // R5 enable load
    write_reg(0, 10'h3E5);
    chk("R5 enable load", enables_o, 6'h25);

    // R2/R6/R7/R11 sweep over all directly pulsed flag combinations
    for (int ei = 0; ei < 4; ei++) begin
      write_reg(0, {4'b0, ens[ei]});
      for (int p = 0; p < 256; p++) begin
        write_reg(1, '0);
        f = {p[7:6], 2'b00, p[5:0]};
        pulse(f);
        chk("R2 flag set", flags_o, f);
        @(negedge clk);
        chk("R6 R7 R11 lines", {irq_grp6, irq_grp4, irq_grp2}, exp_lines(f, ens[ei]));
      end
    end

    // single flag against every enable pattern (R6, R7, R11)
    for (int b = 0; b < 10; b++) begin
      if (b == 6 || b == 7) continue;
      for (int e = 0; e < 64; e++) begin
        write_reg(0, e[9:0]);
        write_reg(1, '0);
        f = 10'b1 << b;
        pulse(f);
        @(negedge clk);
        chk("R6 R7 R11 single", {irq_grp6, irq_grp4, irq_grp2}, exp_lines(f, e[5:0]));
      end
    end

    // R3 write of ones keeps, zeros clear
    write_reg(1, '0);
    pulse(10'h33F);
    write_reg(1, 10'h30A);
    chk("R3 selective clear", flags_o, 10'h30A);

    // R4 set beats clear
    @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_data = '0; ev_spi = 1;
    @(negedge clk);
    wr_en = 0; wr_sel = 0; ev_spi = 0;
    chk("R4 set wins", flags_o, 10'h008);

    // R9 and R8 PLL edges
    write_reg(0, 10'h020);
    write_reg(1, '0);
    @(negedge clk);
    pll_lock = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 rise not early", flags_o[6], 0);
    @(negedge clk);
    chk("R9 rise flag", flags_o[7:6], 2'b01);
    @(negedge clk);
    chk("R8 line4 rise", irq_grp4, 1);
    write_reg(1, '0);
    @(negedge clk);
    chk("R8 line4 drops", irq_grp4, 0);
    pll_lock = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 fall not early", flags_o[7], 0);
    @(negedge clk);
    chk("R9 fall flag", flags_o[7:6], 2'b10);
    @(negedge clk);
    chk("R8 line4 fall", irq_grp4, 1);

    // R10 wake edge behaviour on warning flag
    write_reg(1, '0);
    pulse(10'h004);
    @(negedge clk); wake = 1;
    @(negedge clk);
    chk("R10 rise keeps", flags_o[2], 1);
    wake = 0;
    @(negedge clk);
    chk("R10 fall clears", flags_o[2], 0);
    wake = 1;
    @(negedge clk);
    wake = 0; ev_wdog_near = 1;
    @(negedge clk);
    ev_wdog_near = 0;
    chk("R10 set beats wake fall", flags_o[2], 1);

    // R11 button while awake and asleep
    write_reg(1, '0);
    wake = 1;
    pulse(10'h200);
    chk("R11 button awake", flags_o[9], 1);
    wake = 0;
    write_reg(1, '0);
    pulse(10'h200);
    chk("R11 button asleep", flags_o[9], 1);

    done = 1;
    finish_test();
  end
endmodule